// File: doc/BRIEF.md
# Context-Tagged Address Translation Buffer

This block is a small, fully associative translation cache. It turns a 32-bit virtual address into a 36-bit physical address. Pages are 4 KB, so the low 12 bits pass through unchanged. The upper 20 bits form a virtual page number, which is looked up among 16 resident mappings. Each mapping is stored together with a 12-bit task identifier. Mappings from several tasks can therefore stay resident together, and switching the current task needs no flush.

A lookup is offered on a valid/ready pair and checked against the current task register. On a hit, the physical address comes back one cycle later. On a miss, the block raises a walk request that carries the page number and task, and it stops taking new lookups. It then waits for an external walker to return a physical page number. That result is written into a victim slot and also returned as the response. A single input drops every resident mapping at once.

Top module: `ctx_tlb`

## Requirements
- R1: The response address is the 24-bit physical page number in bits 35:12, concatenated with request address bits 11:0 in bits 11:0. The matched page number is request bits 31:12.
- R2: A lookup accepted at a clock edge, where a valid slot holds the same page number and the same task value, produces `rsp_valid`=1, `rsp_hit`=1 and the stored translation right after that edge.
- R3: A slot matches only when its stored task equals the task register. The task register resets to 0 and takes `ctx_wr_val` at an edge where `ctx_wr_en` is 1. The new value applies to lookups accepted at later edges. A task change removes no slot.
- R4: A lookup that misses raises `walk_req` right after its accepting edge, with `walk_vpn` and `walk_ctx` set to the request's page and task. It holds them until a walk result arrives.
- R5: While `walk_req` is 1, `lk_ready` is 0, and any `lk_valid` is ignored. No response appears, and that address is not looked up later.
- R6: `pte_valid`=1 at an edge while `walk_req` is 1 installs the mapping (request page, request task, `pte_ppn`). Right after that edge, `rsp_valid`=1, `rsp_hit`=0, the address is `pte_ppn` joined with the request offset, and `walk_req` drops. A repeat lookup then hits.
- R7: An install goes to the lowest-numbered invalid slot if one exists. Otherwise it goes to the slot named by a rotating pointer. The pointer starts at 0 and steps by one, wrapping after the last slot, only when it is used.
- R8: `inv_all`=1 at an edge invalidates every slot at that edge. A lookup accepted at the same edge is treated as a miss.
- R9: `pte_valid` with no walk outstanding has no effect: there is no response and no slot is written.
- R10: After reset, `lk_ready`=1, `rsp_valid`=0, `walk_req`=0, and all slots are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted (low during a walk) |
| lk_vaddr | input | 32 | Virtual address to translate |
| ctx_wr_en | input | 1 | Load the task register |
| ctx_wr_val | input | 12 | New task value |
| inv_all | input | 1 | Invalidate every slot |
| rsp_valid | output | 1 | Translation result present for one cycle |
| rsp_hit | output | 1 | 1 when served from a resident slot, 0 after a walk |
| rsp_paddr | output | 36 | Translated physical address |
| walk_req | output | 1 | Table walk outstanding |
| walk_vpn | output | 20 | Page number to walk |
| walk_ctx | output | 12 | Task of the walk |
| pte_valid | input | 1 | Walk result present |
| pte_ppn | input | 24 | Physical page number from the walk |

## Verification
The hardest condition to reach from the ports is a full buffer in which an install has to fall back on the rotating pointer. Before that, every slot must be valid, and the pointer's position depends on the whole history of earlier evictions. The stimulus first invalidates everything. It then fills all sixteen slots with distinct pages and forces a seventeenth miss, so that the oldest resident page must disappear while its neighbour survives. After that, random traffic draws from a page pool larger than the buffer and from three tasks. This causes repeated wrap-around evictions and task switches, which a bench model tracks slot by slot.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
    localparam int VA_W  = 32;
    localparam int PA_W  = 36;
    localparam int CTX_W = 12;
    localparam int OFS_W = 12;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [CTX_W-1:0] ctx_t;
    typedef logic [OFS_W-1:0] ofs_t;

    typedef struct packed {
        vpn_t vpn;
        ctx_t ctx;
        ppn_t ppn;
    } tlb_map_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_st_e;

    function automatic logic [PA_W-1:0] join_pa(ppn_t p, ofs_t o);
        return {p, o};
    endfunction

    function automatic vpn_t va_page(logic [VA_W-1:0] va);
        return va[VA_W-1:OFS_W];
    endfunction

    function automatic ofs_t va_ofs(logic [VA_W-1:0] va);
        return va[OFS_W-1:0];
    endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import ctx_tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inv_all,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_map_t         wr_map,
    input  vpn_t             lk_vpn,
    input  ctx_t             lk_ctx,
    output logic [N_ENT-1:0] valid_vec,
    output logic             any_hit,
    output ppn_t             hit_ppn
);
    tlb_map_t            ent_q [N_ENT];
    logic [N_ENT-1:0]    valid_q;
    logic [N_ENT-1:0]    hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (inv_all) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_q[wr_idx] <= wr_map;
        end
    end

    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_match
        assign hit_vec[gi] = valid_q[gi]
                           && (ent_q[gi].vpn == lk_vpn)
                           && (ent_q[gi].ctx == lk_ctx);
    end

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_vec[i]) begin
                hit_ppn = hit_ppn | ent_q[i].ppn;
            end
        end
    end

    assign any_hit   = |hit_vec;
    assign valid_vec = valid_q;
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ENT-1:0] valid_vec,
    input  logic             use_slot,
    output logic [IDX_W-1:0] vic_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             have_free;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    assign vic_idx = have_free ? free_idx : rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (use_slot && !have_free) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import ctx_tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    output logic            lk_ready,
    input  logic [VA_W-1:0] lk_vaddr,
    input  logic            ctx_wr_en,
    input  ctx_t            ctx_wr_val,
    input  logic            inv_all,
    input  logic            any_hit,
    input  ppn_t            hit_ppn,
    output vpn_t            lk_vpn,
    output ctx_t            lk_ctx,
    input  logic            pte_valid,
    input  ppn_t            pte_ppn,
    output logic            install,
    output tlb_map_t        ins_map,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            walk_req,
    output vpn_t            walk_vpn,
    output ctx_t            walk_ctx
);
    tlb_st_e         st_q;
    ctx_t            ctx_q;
    vpn_t            req_vpn_q;
    ofs_t            req_ofs_q;
    ctx_t            req_ctx_q;
    logic            rsp_valid_q;
    logic            rsp_hit_q;
    logic [PA_W-1:0] rsp_pa_q;
    logic            accept;
    logic            hit_ok;

    assign lk_ready = (st_q == ST_IDLE);
    assign accept   = lk_valid && lk_ready;
    assign lk_vpn   = va_page(lk_vaddr);
    assign lk_ctx   = ctx_q;
    assign hit_ok   = any_hit && !inv_all;
    assign install  = (st_q == ST_WALK) && pte_valid;
    assign ins_map  = '{vpn: req_vpn_q, ctx: req_ctx_q, ppn: pte_ppn};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            ctx_q       <= '0;
            req_vpn_q   <= '0;
            req_ofs_q   <= '0;
            req_ctx_q   <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_pa_q    <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (ctx_wr_en) begin
                ctx_q <= ctx_wr_val;
            end
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (hit_ok) begin
                            rsp_valid_q <= 1'b1;
                            rsp_hit_q   <= 1'b1;
                            rsp_pa_q    <= join_pa(hit_ppn, va_ofs(lk_vaddr));
                        end else begin
                            st_q      <= ST_WALK;
                            req_vpn_q <= lk_vpn;
                            req_ofs_q <= va_ofs(lk_vaddr);
                            req_ctx_q <= ctx_q;
                        end
                    end
                end
                ST_WALK: begin
                    if (pte_valid) begin
                        rsp_valid_q <= 1'b1;
                        rsp_hit_q   <= 1'b0;
                        rsp_pa_q    <= join_pa(pte_ppn, req_ofs_q);
                        st_q        <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_paddr = rsp_pa_q;
    assign walk_req  = (st_q == ST_WALK);
    assign walk_vpn  = req_vpn_q;
    assign walk_ctx  = req_ctx_q;
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              ctx_wr_en,
    input  logic [CTX_W-1:0]  ctx_wr_val,
    input  logic              inv_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic [CTX_W-1:0]  walk_ctx,
    input  logic              pte_valid,
    input  logic [PPN_W-1:0]  pte_ppn
);
    logic [N_ENT-1:0] valid_vec;
    logic             any_hit;
    ppn_t             hit_ppn;
    vpn_t             lk_vpn;
    ctx_t             lk_ctx;
    logic             install;
    tlb_map_t         ins_map;
    logic [IDX_W-1:0] vic_idx;

    tlb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (lk_valid),
        .lk_ready   (lk_ready),
        .lk_vaddr   (lk_vaddr),
        .ctx_wr_en  (ctx_wr_en),
        .ctx_wr_val (ctx_wr_val),
        .inv_all    (inv_all),
        .any_hit    (any_hit),
        .hit_ppn    (hit_ppn),
        .lk_vpn     (lk_vpn),
        .lk_ctx     (lk_ctx),
        .pte_valid  (pte_valid),
        .pte_ppn    (pte_ppn),
        .install    (install),
        .ins_map    (ins_map),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_paddr  (rsp_paddr),
        .walk_req   (walk_req),
        .walk_vpn   (walk_vpn),
        .walk_ctx   (walk_ctx)
    );

    tlb_entry_array #(.N_ENT(N_ENT)) u_arr (
        .clk       (clk),
        .rst       (rst),
        .inv_all   (inv_all),
        .wr_en     (install),
        .wr_idx    (vic_idx),
        .wr_map    (ins_map),
        .lk_vpn    (lk_vpn),
        .lk_ctx    (lk_ctx),
        .valid_vec (valid_vec),
        .any_hit   (any_hit),
        .hit_ppn   (hit_ppn)
    );

    tlb_victim_sel #(.N_ENT(N_ENT)) u_vic (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .use_slot  (install),
        .vic_idx   (vic_idx)
    );
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk
    import ctx_tlb_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             lk_ready,
    input ofs_t             lk_ofs,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input ofs_t             rsp_ofs,
    input logic             walk_req,
    input vpn_t             walk_vpn,
    input logic             pte_valid,
    input logic             inv_all,
    input logic [N_ENT-1:0] valid_vec
);
    // R5: no lookup is taken while a walk is outstanding
    a_r5_no_ready_in_walk: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> !lk_ready);

    // R2 and R4: an accepted lookup leads to exactly one of hit response or walk
    a_r2_hit_or_walk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> ((rsp_valid && rsp_hit) != walk_req));

    // R1: a hit response keeps the request offset
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready) |=> (!rsp_valid || rsp_ofs == $past(lk_ofs)));

    // R4: walk request and its page stay put until a result arrives
    a_r4_walk_held: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !pte_valid) |=> (walk_req && $stable(walk_vpn)));

    // R6: a walk result completes the miss with a non-hit response
    a_r6_refill_done: assert property (@(posedge clk) disable iff (rst)
        (walk_req && pte_valid) |=> (rsp_valid && !rsp_hit && !walk_req));

    // R8: invalidate empties the buffer in one cycle
    a_r8_all_cleared: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (valid_vec == '0));

    // R9: without an accept or a walk, no response shows up
    a_r9_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        (!walk_req && !(lk_valid && lk_ready)) |=> !rsp_valid);

    // R10: reset state
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (lk_ready && !rsp_valid && !walk_req && valid_vec == '0));
endmodule

bind ctx_tlb ctx_tlb_chk #(.N_ENT(N_ENT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .lk_ofs    (lk_vaddr[11:0]),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_ofs   (rsp_paddr[11:0]),
    .walk_req  (walk_req),
    .walk_vpn  (walk_vpn),
    .pte_valid (pte_valid),
    .inv_all   (inv_all),
    .valid_vec (valid_vec)
);

// File: tb/tb_ctx_tlb.sv
module tb_ctx_tlb;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic        lk_ready;
    logic [31:0] lk_vaddr;
    logic        ctx_wr_en;
    logic [11:0] ctx_wr_val;
    logic        inv_all;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [35:0] rsp_paddr;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic [11:0] walk_ctx;
    logic        pte_valid;
    logic [23:0] pte_ppn;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model of resident mappings
    bit          m_val [NE];
    logic [19:0] m_vpn [NE];
    logic [11:0] m_ctx [NE];
    logic [23:0] m_ppn [NE];
    int          m_rr;
    logic [11:0] m_cur;

    always #10 clk = ~clk;

    ctx_tlb dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
        .lk_vaddr(lk_vaddr), .ctx_wr_en(ctx_wr_en), .ctx_wr_val(ctx_wr_val),
        .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_paddr(rsp_paddr), .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_ctx(walk_ctx), .pte_valid(pte_valid), .pte_ppn(pte_ppn)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_find(input logic [19:0] v, input logic [11:0] c);
        for (int i = 0; i < NE; i++)
            if (m_val[i] && m_vpn[i] == v && m_ctx[i] == c) return i;
        return -1;
    endfunction

    task automatic model_install(input logic [19:0] v, input logic [11:0] c,
                                 input logic [23:0] p);
        int slot = -1;
        for (int i = NE - 1; i >= 0; i--) if (!m_val[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % NE;
        end
        m_val[slot] = 1'b1; m_vpn[slot] = v; m_ctx[slot] = c; m_ppn[slot] = p;
    endtask

    task automatic model_clear();
        for (int i = 0; i < NE; i++) m_val[i] = 1'b0;
    endtask

    // one lookup; on a miss the walk is answered with ppn after stall cycles
    task automatic lookup(input logic [31:0] va, input logic [23:0] ppn,
                          input int stall, input bit with_inv, input string tag);
        int slot;
        if (with_inv) model_clear();
        slot = model_find(va[31:12], m_cur);
        @(negedge clk);
        check(lk_ready == 1'b1, {tag, " ready before lookup"}, lk_ready, 1);
        lk_valid = 1'b1; lk_vaddr = va; inv_all = with_inv;
        @(negedge clk);
        lk_valid = 1'b0; inv_all = 1'b0;
        if (slot >= 0) begin
            check(rsp_valid && rsp_hit && !walk_req, {tag, " hit flags"},
                  {rsp_valid, rsp_hit, walk_req}, 3'b110);
            check(rsp_paddr == {m_ppn[slot], va[11:0]}, {tag, " R1 hit address"},
                  rsp_paddr, {m_ppn[slot], va[11:0]});
        end else begin
            check(walk_req && !rsp_valid && !lk_ready, {tag, " R4 miss raises walk"},
                  {walk_req, rsp_valid, lk_ready}, 3'b100);
            check(walk_vpn == va[31:12] && walk_ctx == m_cur, {tag, " R4 walk fields"},
                  {walk_ctx, walk_vpn}, {m_cur, va[31:12]});
            for (int k = 0; k < stall; k++) begin
                lk_valid = 1'b1; lk_vaddr = $urandom;
                @(negedge clk);
                check(walk_req && !lk_ready && !rsp_valid, {tag, " R5 back-pressure"},
                      {walk_req, lk_ready, rsp_valid}, 3'b100);
            end
            lk_valid = 1'b0;
            pte_valid = 1'b1; pte_ppn = ppn;
            @(negedge clk);
            pte_valid = 1'b0;
            check(rsp_valid && !rsp_hit && !walk_req && lk_ready, {tag, " R6 refill flags"},
                  {rsp_valid, rsp_hit, walk_req, lk_ready}, 4'b1001);
            check(rsp_paddr == {ppn, va[11:0]}, {tag, " R6 refill address"},
                  rsp_paddr, {ppn, va[11:0]});
            model_install(va[31:12], m_cur, ppn);
        end
    endtask

    task automatic set_ctx(input logic [11:0] c);
        @(negedge clk);
        ctx_wr_en = 1'b1; ctx_wr_val = c;
        @(negedge clk);
        ctx_wr_en = 1'b0;
        m_cur = c;
    endtask

    task automatic invalidate();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        model_clear();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        rst = 1'b1; lk_valid = 1'b0; lk_vaddr = '0; ctx_wr_en = 1'b0;
        ctx_wr_val = '0; inv_all = 1'b0; pte_valid = 1'b0; pte_ppn = '0;
        model_clear(); m_rr = 0; m_cur = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(lk_ready && !rsp_valid && !walk_req, "R10 reset outputs",
              {lk_ready, rsp_valid, walk_req}, 3'b100);

        // R4 R5 R6: first miss with back-pressure, then R2 hit
        lookup(32'h1234_5678, 24'hABCDEF, 3, 1'b0, "R4");
        lookup(32'h1234_5FFF, 24'h0, 0, 1'b0, "R2");

        // R9: stray walk result is ignored
        @(negedge clk);
        pte_valid = 1'b1; pte_ppn = 24'h777777;
        @(negedge clk);
        pte_valid = 1'b0;
        check(!rsp_valid && !walk_req, "R9 stray result no response",
              {rsp_valid, walk_req}, 2'b00);
        lookup(32'h0000_0123, 24'h111111, 0, 1'b0, "R9 nothing installed");

        // R3: other task misses, original mapping survives the switch back
        set_ctx(12'h005);
        lookup(32'h1234_5000, 24'h222222, 1, 1'b0, "R3 other task");
        set_ctx(12'h000);
        lookup(32'h1234_5ABC, 24'h0, 0, 1'b0, "R3 back to task 0");
        set_ctx(12'h005);
        lookup(32'h1234_5004, 24'h0, 0, 1'b0, "R3 task 5 resident");
        set_ctx(12'h000);

        // R8: invalidate, then R7 fill all slots and evict the oldest
        invalidate();
        lookup(32'h1234_5678, 24'h300000, 0, 1'b0, "R8 after invalidate");
        for (int i = 1; i < NE; i++)
            lookup({20'h40000 + 20'(i), 12'h010}, 24'h300000 + 24'(i), 0, 1'b0, "R7 fill");
        lookup(32'h5000_0000, 24'h3FFFFF, 0, 1'b0, "R7 evict pointer slot");
        lookup(32'h4000_1020, 24'h0, 0, 1'b0, "R7 neighbour kept");
        lookup(32'h1234_5678, 24'h3ABCDE, 0, 1'b0, "R7 oldest evicted");

        // R8: invalidate in the same cycle as an accepted lookup
        lookup(32'h4000_2000, 24'h3C0C0C, 0, 1'b1, "R8 same-cycle invalidate");

        // random mix
        for (int it = 0; it < 600; it++) begin
            int unsigned r = $urandom % 40;
            if (r < 3) begin
                set_ctx(12'($urandom % 3));
            end else if (r == 3) begin
                invalidate();
            end else begin
                lookup({20'h8000 + 20'($urandom % 24), 12'($urandom)},
                       24'($urandom), int'($urandom % 3), 1'b0, "R2 R6 R7 random");
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule